// File: doc/BRIEF.md
# Radix-4 Digit-Serial On-Line Adder

This block adds two numbers that arrive one signed digit per clock, most significant digit first. Every digit is radix 4 and drawn from the symmetric set -3..+3, which is the most redundant set a radix-4 digit can have. The sum leaves the block in the same digit format, one digit per accepted input pair, with an on-line delay of one digit. No carry ever travels across digits: each cycle the new digit pair is merged into a small residual through a carry-save layer. The next output digit is then chosen by rounding that residual, so the cycle time does not grow with operand precision.

An operand of n digits is followed by one pair of zero digits. That flush pair drives the residual to zero, so the n+1 output digits carry the exact sum. The extra leading digit is the integer part made necessary by the one-digit delay. A `start` strobe marks the first digit of a new operation and discards whatever residual was left. Cycles with `in_valid` low are gaps: they neither produce output nor change the residual. Conversion to or from two's complement is outside the block.

Top module: `olad_adder`

## Requirements
- R1: Every digit at the ports is a 3-bit two's complement code of a value in -3..+3 (+3 = 011, +1 = 001, 0 = 000, -1 = 111, -3 = 101). The code 100 never appears on `z_digit` while `out_valid` is high.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, so one output digit is produced per input pair. After reset `out_valid` and `z_digit` are 0.
- R3: When `start` is high together with `in_valid`, that digit is combined with a zero residual. A residual left by an unfinished operation therefore has no effect on the new result.
- R4: For n input digit pairs followed by one zero flush pair, the n+1 output digits read as Z = sum of z_k·4^(n+1-k) (k = 1..n+1) equal X + Y, where X = sum of x_k·4^(n-k).
- R5: With residual w = 4·p + x + y in quarter-digit units, the output digit is w/4 rounded to the nearest integer, halves rounded away from zero when TIE_AWAY = 1. A first pair of 3,3 yields +2, a first pair of -3,-3 yields -2, a first pair of 1,2 yields +1 and a first pair of 1,0 yields 0.
- R6: Full-scale operands (all digits +3 or all digits -3) keep the residual within -2..+2 quarter units, and every output digit stays within -3..+3.
- R7: A cycle with `in_valid` and `start` both low leaves the residual unchanged, so idle gaps inside an operation do not alter the sum.
- R8: An accepted zero digit pair leaves a zero residual, so an operation that follows a flushed one gives the exact sum even without `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | First digit of a new operation; clears the residual |
| in_valid | input | 1 | The digit pair on `x_digit` and `y_digit` is accepted this cycle |
| x_digit | input | 3 | Digit of the first operand, radix 4, two's complement code |
| y_digit | input | 3 | Digit of the second operand, radix 4, two's complement code |
| out_valid | output | 1 | `z_digit` holds a sum digit |
| z_digit | output | 3 | Sum digit, radix 4, two's complement code |

## Verification
The bench targets the tie point of the rounding. A pair summing to ±6 lands exactly halfway between two digits: a design that rounds the wrong way still gives the right total but emits a wrong first digit. Full-scale operands push the residual to its edge. A design without the clamp to ±3 would emit the illegal code 100 or overflow the residual, and the reassembled sum would come out wrong. Two further cases are an operation aborted halfway and then restarted, and idle gaps inside an operation. Each catches a design that keeps a stale residual or lets the residual drift during an idle cycle. A back-to-back operation without `start` shows whether the flush digit truly empties the residual.

// File: rtl/olad_pkg.sv
package olad_pkg;
   localparam int DIGIT_W   = 3;   // radix-4 digit, two's complement code
   localparam int DIGIT_MAX = 3;   // largest digit magnitude (r - 1)
   localparam int FRAC_W    = 2;   // log2 of the radix: one digit shift
endpackage

// File: rtl/olad_csa.sv
// Bitwise 3:2 compressor: three vectors in, sum and shifted carry out.
module olad_csa #(
   parameter int W = 6
) (
   input  logic [W-1:0] a_vec,
   input  logic [W-1:0] b_vec,
   input  logic [W-1:0] c_vec,
   output logic [W-1:0] sum_vec,
   output logic [W-1:0] cry_vec
);
   if (W < 2) begin : g_bad_w
      $error("olad_csa: W must be at least 2");
   end

   assign cry_vec[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_vec[i] = a_vec[i] ^ b_vec[i] ^ c_vec[i];
      if (i < W - 1) begin : g_cry
         assign cry_vec[i+1] = (a_vec[i] & b_vec[i]) | (a_vec[i] & c_vec[i])
                             | (b_vec[i] & c_vec[i]);
      end
   end
endmodule

// File: rtl/olad_select.sv
// Digit selection: round w/4 to the nearest digit, clamp to the digit set,
// and return the remaining residual w - 4*z.
module olad_select
   import olad_pkg::*;
#(
   parameter int W_W      = 6,
   parameter int RES_W    = 4,
   parameter bit TIE_AWAY = 1'b1
) (
   input  logic signed [W_W-1:0]     w_val,
   output logic [DIGIT_W-1:0]        z_out,
   output logic signed [RES_W-1:0]   rem_out
);
   localparam int Q_W = W_W - FRAC_W + 1;

   if (W_W < 6) begin : g_bad_w
      $error("olad_select: W_W must hold the range -14..14");
   end
   if (RES_W + FRAC_W != W_W) begin : g_bad_res
      $error("olad_select: RES_W must equal W_W minus FRAC_W");
   end

   localparam logic signed [Q_W-1:0] Q_MAX = Q_W'(DIGIT_MAX);
   localparam logic signed [Q_W-1:0] Q_MIN = -Q_W'(DIGIT_MAX);

   logic signed [W_W-FRAC_W-1:0] q_floor;
   logic [FRAC_W-1:0]            frac;
   logic                         tie_up;
   logic                         rnd_up;
   logic signed [Q_W-1:0]        q_rnd;

   assign q_floor = signed'(w_val[W_W-1:FRAC_W]);
   assign frac    = w_val[FRAC_W-1:0];

   // Tie handling chosen at elaboration.
   if (TIE_AWAY) begin : g_tie_away
      assign tie_up = ~w_val[W_W-1];
   end else begin : g_tie_zero
      assign tie_up = w_val[W_W-1];
   end

   // frac == 3: round up, frac == 2: tie, frac < 2: keep the floor.
   assign rnd_up = frac[1] & (frac[0] | tie_up);
   assign q_rnd  = {q_floor[W_W-FRAC_W-1], q_floor} + {{(Q_W-1){1'b0}}, rnd_up};

   always_comb begin
      if (q_rnd > Q_MAX)      z_out = DIGIT_W'(DIGIT_MAX);
      else if (q_rnd < Q_MIN) z_out = -DIGIT_W'(DIGIT_MAX);
      else                    z_out = q_rnd[DIGIT_W-1:0];
   end

   assign rem_out = RES_W'(w_val - (W_W'(signed'(z_out)) <<< FRAC_W));
endmodule

// File: rtl/olad_adder.sv
// Radix-4 on-line adder, on-line delay of one digit.
module olad_adder
   import olad_pkg::*;
#(
   parameter int RES_W    = 4,
   parameter bit TIE_AWAY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               in_valid,
   input  logic [DIGIT_W-1:0] x_digit,
   input  logic [DIGIT_W-1:0] y_digit,
   output logic               out_valid,
   output logic [DIGIT_W-1:0] z_digit
);
   localparam int W_W = RES_W + FRAC_W;

   if (RES_W < 4) begin : g_bad_res
      $error("olad_adder: RES_W below 4 cannot hold the residual range");
   end

   logic signed [RES_W-1:0] p_q;
   logic signed [RES_W-1:0] p_eff;
   logic [W_W-1:0]          a_op, b_op, c_op;
   logic [W_W-1:0]          s_vec, c_vec;
   logic signed [W_W-1:0]   w_val;
   logic [DIGIT_W-1:0]      z_sel;
   logic signed [RES_W-1:0] rem;

   assign p_eff = start ? '0 : p_q;
   assign a_op  = {p_eff, {FRAC_W{1'b0}}};
   assign b_op  = {{(W_W-DIGIT_W){x_digit[DIGIT_W-1]}}, x_digit};
   assign c_op  = {{(W_W-DIGIT_W){y_digit[DIGIT_W-1]}}, y_digit};

   olad_csa #(.W(W_W)) u_csa (
      .a_vec  (a_op),
      .b_vec  (b_op),
      .c_vec  (c_op),
      .sum_vec(s_vec),
      .cry_vec(c_vec)
   );

   assign w_val = signed'(s_vec + c_vec);

   olad_select #(.W_W(W_W), .RES_W(RES_W), .TIE_AWAY(TIE_AWAY)) u_sel (
      .w_val  (w_val),
      .z_out  (z_sel),
      .rem_out(rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q       <= '0;
         out_valid <= 1'b0;
         z_digit   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            p_q     <= rem;
            z_digit <= z_sel;
         end else if (start) begin
            p_q <= '0;
         end
      end
   end

   // R2: one output digit in the cycle after each accepted pair
   p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R1: the unused code never leaves the block
   p_digit_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> z_digit != 3'b100);
   // R6: residual stays inside half a digit
   p_resid_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (p_q >= -2) && (p_q <= 2));
   // R7: gaps leave the residual alone
   p_hold_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid && !start |=> $stable(p_q));
   // R3: a lone start clears the residual
   p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start && !in_valid |=> p_q == '0);
   // R8: a zero digit pair empties the residual
   p_flush_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && x_digit == '0 && y_digit == '0 |=> p_q == '0);
endmodule

// File: tb/tb_olad_adder.sv
`timescale 1ns/1ps
module tb_olad_adder;
   localparam int N  = 4;
   localparam int ND = N + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] x_d = 3'b000;
   logic [2:0] y_d = 3'b000;
   logic       out_valid;
   logic [2:0] z_d;

   always #2 clk = ~clk;

   olad_adder dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .x_digit(x_d), .y_digit(y_d), .out_valid(out_valid), .z_digit(z_d)
   );

   int    checks = 0;
   int    errors = 0;
   int    exp_q[$];
   string tag_q[$];
   int    last_z[ND];
   int    done_cnt = 0;
   int    acc = 0;
   int    cnt = 0;
   int    dgt, ev;
   string tg;
   int    xa[N];
   int    ya[N];
   logic  first_q = 1'b0;
   logic  vin_q = 1'b0;

   always @(posedge clk) begin
      first_q <= start & in_valid;
      vin_q   <= in_valid;
   end

   function automatic logic [2:0] enc(int d);
      return 3'(d);
   endfunction

   function automatic int dec(logic [2:0] c);
      return int'(signed'(c));
   endfunction

   task automatic check(bit ok, string req, int act, int expv, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         check(out_valid == vin_q, "R2", int'(out_valid), int'(vin_q), "valid lag");
         if (out_valid) begin
            dgt = dec(z_d);
            check(z_d != 3'b100 && dgt >= -3 && dgt <= 3, "R1", dgt, 3, "digit in -3..3");
            if (first_q) begin
               acc = 0;
               cnt = 0;
            end
            last_z[cnt] = dgt;
            acc = acc * 4 + dgt;
            cnt++;
            if (cnt == ND) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4", acc, 0, "unexpected result");
               end else begin
                  ev = exp_q.pop_front();
                  tg = tag_q.pop_front();
                  check(acc == ev, tg, acc, ev, "sum");
               end
               cnt = 0;
               acc = 0;
               done_cnt++;
            end
         end
      end
   end

   task automatic run_op(int xs[N], int ys[N], bit use_start, int gap_at, string tag);
      int sx = 0;
      int sy = 0;
      for (int k = 0; k < N; k++) begin
         sx = sx * 4 + xs[k];
         sy = sy * 4 + ys[k];
      end
      exp_q.push_back(sx + sy);
      tag_q.push_back(tag);
      for (int k = 0; k <= N; k++) begin
         if (k == gap_at && k > 0) begin
            repeat (2) begin
               @(posedge clk); #1;
               in_valid = 1'b0;
               start    = 1'b0;
            end
         end
         @(posedge clk); #1;
         start    = use_start && (k == 0);
         in_valid = 1'b1;
         x_d      = (k < N) ? enc(xs[k]) : 3'b000;
         y_d      = (k < N) ? enc(ys[k]) : 3'b000;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      start    = 1'b0;
   endtask

   task automatic wait_done(int target);
      int guard = 0;
      while (done_cnt < target && guard < 200) begin
         @(posedge clk);
         guard++;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      check(1'b0, "watchdog", 0, 1, "run did not finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R2", int'(out_valid), 0, "reset valid");
      check(z_d == 3'b000, "R2", dec(z_d), 0, "reset digit");
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R5: rounding of the first digit, including the halfway points
      xa = '{3, 0, 0, 0}; ya = '{3, 0, 0, 0};
      run_op(xa, ya, 1'b1, -1, "R4");
      wait_done(1);
      check(last_z[0] == 2, "R5", last_z[0], 2, "tie +1.5 first digit");
      check(last_z[1] == -2, "R5", last_z[1], -2, "second digit after tie");
      xa = '{-3, 0, 0, 0}; ya = '{-3, 0, 0, 0};
      run_op(xa, ya, 1'b1, -1, "R4");
      wait_done(2);
      check(last_z[0] == -2, "R5", last_z[0], -2, "tie -1.5 first digit");
      xa = '{1, 0, 0, 0}; ya = '{2, 0, 0, 0};
      run_op(xa, ya, 1'b1, -1, "R4");
      wait_done(3);
      check(last_z[0] == 1, "R5", last_z[0], 1, "0.75 rounds up");
      xa = '{1, 0, 0, 0}; ya = '{0, 0, 0, 0};
      run_op(xa, ya, 1'b1, -1, "R4");
      wait_done(4);
      check(last_z[0] == 0, "R5", last_z[0], 0, "0.25 rounds down");

      // R6: full-scale operands
      xa = '{3, 3, 3, 3}; ya = '{3, 3, 3, 3};
      run_op(xa, ya, 1'b1, -1, "R6");
      xa = '{-3, -3, -3, -3}; ya = '{-3, -3, -3, -3};
      run_op(xa, ya, 1'b1, -1, "R6");
      xa = '{3, -3, 3, -3}; ya = '{3, -3, 3, -3};
      run_op(xa, ya, 1'b1, -1, "R6");
      wait_done(7);

      // R7: idle gaps inside an operation
      xa = '{2, -1, 3, 1}; ya = '{3, 2, -2, 3};
      run_op(xa, ya, 1'b1, 2, "R7");
      xa = '{-3, 3, 1, -2}; ya = '{-2, 3, 3, 3};
      run_op(xa, ya, 1'b1, 1, "R7");
      wait_done(9);

      // R3: abort an operation with a nonzero residual, then restart
      @(posedge clk); #1;
      start = 1'b1; in_valid = 1'b1; x_d = enc(3); y_d = enc(3);
      @(posedge clk); #1;
      start = 1'b0; x_d = enc(1); y_d = enc(2);
      @(posedge clk); #1;
      in_valid = 1'b0;
      xa = '{0, 1, 0, 0}; ya = '{0, 0, 0, 0};
      run_op(xa, ya, 1'b1, -1, "R3");
      wait_done(10);

      // R8: back-to-back operations without start after a flush
      xa = '{3, 1, -2, 2}; ya = '{3, 3, 0, -1};
      run_op(xa, ya, 1'b1, -1, "R4");
      xa = '{-1, 2, 3, 3}; ya = '{2, -3, 3, 1};
      run_op(xa, ya, 1'b0, -1, "R8");
      xa = '{1, 1, 1, 3}; ya = '{3, 3, 3, 2};
      run_op(xa, ya, 1'b0, -1, "R8");
      wait_done(13);

      // R4: random operands
      for (int i = 0; i < 40; i++) begin
         for (int k = 0; k < N; k++) begin
            xa[k] = int'($urandom_range(6)) - 3;
            ya[k] = int'($urandom_range(6)) - 3;
         end
         run_op(xa, ya, (i % 3) != 0, (i % 5 == 4) ? 3 : -1, "R4");
      end
      wait_done(53);
      check(exp_q.size() == 0, "R4", exp_q.size(), 0, "results outstanding");
      finish_run();
   end
endmodule